// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timing Controller

This block runs single read and write cycles on an asynchronous external memory bus, such as one driving a NAND flash device. A configuration word sets the timing. Reads and writes each have their own setup, strobe and hold widths. The word also holds a turnaround gap, a data-bus size code, a bit that selects how chip select behaves, and an enable that lets the wait input stretch the strobe. A second configuration word holds, for each chip select, a NAND-mode enable and an ECC-start flag. The block only presents these flags on its outputs. It does no ECC arithmetic and no NAND command sequencing.

A client raises `req` with a direction, chip select, address and write data. The controller takes the request when `req_ready` is high. It then drives chip select, output enable or write enable, the address and the data lines through the three phases. On the final hold cycle it pulses `done`. Read data is captured at the end of the strobe phase. A new access cannot start until the turnaround gap has passed.

Top module: `async_strobe_seq`

## Requirements
- R1: A configuration write with `cfg_sel`=0 loads the timing word. Its fields are: read setup [3:0], read strobe [9:4], read hold [12:10], write setup [16:13], write strobe [22:17], write hold [25:23], turnaround [27:26], bus size [28], extended-wait enable [29] and strobe select [30]. Every width field gives N+1 clock cycles for a value of N. Reset clears the whole word.
- R2: A read lasts (rs+1)+(rst+1)+(rh+1) cycles. With read setup 2, strobe 7 and hold 0, a read gives 3 setup, 8 strobe and 1 hold cycles.
- R3: A write uses the write fields. With setup 0, strobe 6 and hold 1, a write gives 1+7+2 cycles. `mem_doe` is high and `mem_dout` carries the write data for all of those cycles.
- R4: `mem_oe_n` is low only during the strobe of a read, and `mem_we_n` is low only during the strobe of a write. The two are never low together.
- R5: On a read, `rdata` takes the value of `mem_din` present on the last strobe cycle.
- R6: `req_ready` is high only when no access is in progress and the turnaround has expired. A request is taken only then. `done` is high for exactly one cycle, the last hold cycle.
- R7: After `done`, at least turnaround+1 cycles pass with every chip select inactive before the next setup begins. With turnaround 2, back-to-back requests see exactly 3 such cycles.
- R8: With extended wait enabled, a high `mem_wait` on the final strobe cycle holds the strobe until `mem_wait` falls. With the enable clear, `mem_wait` has no effect on the access length.
- R9: With strobe select 0 (normal), the chip select is low through setup, strobe and hold. With strobe select 1, it is low only during the strobe.
- R10: Bus size 0 selects an 8-bit bus: `mem_dout` and `rdata` carry only the low byte, and the upper byte is zero. Bus size 1 uses all 16 bits.
- R11: Only the chip select line numbered `req_cs` (active low) is asserted. At most one line is low at any time.
- R12: A configuration write with `cfg_sel`=1 loads the per-chip-select flags: NAND enable in [3:0] and ECC start in [7:4], bit i for chip select i. They appear on `cs_nand` and `cs_ecc_start`. Reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = timing word, 1 = chip-select flag word |
| cfg_wdata | input | 31 | Configuration write data |
| req | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Target chip select |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller can take a request |
| done | output | 1 | Last hold cycle of an access |
| rdata | output | 16 | Captured read data |
| mem_cs_n | output | 4 | Chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 16 | Memory address |
| mem_dout | output | 16 | Write data to memory |
| mem_doe | output | 1 | Data output enable |
| mem_din | input | 16 | Read data from memory |
| mem_wait | input | 1 | Wait (stall) from memory |
| cs_nand | output | 4 | NAND-mode enable per chip select |
| cs_ecc_start | output | 4 | ECC-start flag per chip select |

## Verification
The bench measures each phase of the example read and write timings cycle by cycle. A design with an off-by-one in the minus-one encoding would show setup, strobe or hold lengths one cycle short or long. During the strobe, the bench changes the read data on every cycle. If the capture came one cycle early or late, `rdata` would hold a neighbouring value. The bench drives `mem_wait` high both with the extended-wait enable set and with it clear, which catches a design that ignores the enable. It also issues back-to-back requests to measure the turnaround gap, which fails if the gap is short or missing. Strobe-select mode, 8-bit masking and per-chip-select flag decoding are each checked against their own values.

// File: rtl/async_strobe_seq.sv
module async_strobe_seq #(
  parameter int ADDR_W   = 16,
  parameter int NUM_CS   = 4,
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 3,
  parameter int TA_W     = 2,
  localparam int CS_W    = $clog2(NUM_CS),
  localparam int TIM_W   = 2 * (SETUP_W + STROBE_W + HOLD_W) + TA_W + 3,
  localparam int CFG_W   = (TIM_W > 2 * NUM_CS) ? TIM_W : 2 * NUM_CS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req,
  input  logic              req_write,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [15:0]       rdata,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_dout,
  output logic              mem_doe,
  input  logic [15:0]       mem_din,
  input  logic              mem_wait,
  output logic [NUM_CS-1:0] cs_nand,
  output logic [NUM_CS-1:0] cs_ecc_start
);

  localparam int RST_LO = SETUP_W;
  localparam int RH_LO  = RST_LO + STROBE_W;
  localparam int WS_LO  = RH_LO + HOLD_W;
  localparam int WST_LO = WS_LO + SETUP_W;
  localparam int WH_LO  = WST_LO + STROBE_W;
  localparam int TA_LO  = WH_LO + HOLD_W;
  localparam int B16_B  = TA_LO + TA_W;
  localparam int EW_B   = B16_B + 1;
  localparam int SS_B   = B16_B + 2;
  localparam int MX1    = (SETUP_W > STROBE_W) ? SETUP_W : STROBE_W;
  localparam int CNT_W  = (MX1 > HOLD_W) ? MX1 : HOLD_W;

  typedef enum logic [1:0] {IDLE, SETUP, STROBE, HOLD} phase_t;

  logic [TIM_W-1:0]    tim;
  logic [2*NUM_CS-1:0] flags;
  phase_t              phase;
  logic [CNT_W-1:0]    cnt;
  logic [TA_W-1:0]     ta_cnt;
  logic                cur_wr;
  logic [CS_W-1:0]     cur_cs;
  logic [ADDR_W-1:0]   cur_addr;
  logic [15:0]         cur_wdata;

  wire bus16   = tim[B16_B];
  wire ew_en   = tim[EW_B];
  wire sel_str = tim[SS_B];
  wire [SETUP_W-1:0]  rs  = tim[SETUP_W-1:0];
  wire [STROBE_W-1:0] rst = tim[RST_LO +: STROBE_W];
  wire [HOLD_W-1:0]   rh  = tim[RH_LO +: HOLD_W];
  wire [SETUP_W-1:0]  ws  = tim[WS_LO +: SETUP_W];
  wire [STROBE_W-1:0] wst = tim[WST_LO +: STROBE_W];
  wire [HOLD_W-1:0]   wh  = tim[WH_LO +: HOLD_W];
  wire [TA_W-1:0]     ta  = tim[TA_LO +: TA_W];

  wire last    = (cnt == '0);
  wire stall   = ew_en && mem_wait;
  wire accept  = req && req_ready;
  wire cs_act  = sel_str ? (phase == STROBE) : (phase != IDLE);

  assign req_ready    = (phase == IDLE) && (ta_cnt == '0);
  assign done         = (phase == HOLD) && last;
  assign mem_addr     = cur_addr;
  assign mem_cs_n     = cs_act ? ~(NUM_CS'(1) << cur_cs) : '1;
  assign mem_oe_n     = !((phase == STROBE) && !cur_wr);
  assign mem_we_n     = !((phase == STROBE) && cur_wr);
  assign mem_doe      = cur_wr && (phase != IDLE);
  assign mem_dout     = bus16 ? cur_wdata : {8'h00, cur_wdata[7:0]};
  assign cs_nand      = flags[NUM_CS-1:0];
  assign cs_ecc_start = flags[2*NUM_CS-1:NUM_CS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim   <= '0;
      flags <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) flags <= cfg_wdata[2*NUM_CS-1:0];
      else         tim   <= cfg_wdata[TIM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= IDLE;
      cnt       <= '0;
      ta_cnt    <= '0;
      cur_wr    <= 1'b0;
      cur_cs    <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rdata     <= '0;
    end else begin
      case (phase)
        IDLE: begin
          if (ta_cnt != '0) ta_cnt <= ta_cnt - 1'b1;
          if (accept) begin
            phase     <= SETUP;
            cur_wr    <= req_write;
            cur_cs    <= req_cs;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            cnt       <= req_write ? CNT_W'(ws) : CNT_W'(rs);
          end
        end
        SETUP: begin
          if (last) begin
            phase <= STROBE;
            cnt   <= cur_wr ? CNT_W'(wst) : CNT_W'(rst);
          end else cnt <= cnt - 1'b1;
        end
        STROBE: begin
          if (!last) cnt <= cnt - 1'b1;
          else if (!stall) begin
            phase <= HOLD;
            cnt   <= cur_wr ? CNT_W'(wh) : CNT_W'(rh);
            if (!cur_wr) rdata <= bus16 ? mem_din : {8'h00, mem_din[7:0]};
          end
        end
        HOLD: begin
          if (last) begin
            phase  <= IDLE;
            ta_cnt <= ta;
          end else cnt <= cnt - 1'b1;
        end
        default: phase <= IDLE;
      endcase
    end
  end

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r11_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  a_r6_ready_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&mem_cs_n) && mem_oe_n && mem_we_n && !mem_doe);

  a_r6_done_ends_access: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (&mem_cs_n) && !mem_doe && !done);

  a_r7_no_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ta != '0) |=> !req_ready);

  a_r8_wait_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == STROBE && last && !ew_en) |=> phase == HOLD);

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != IDLE && $past(phase) != IDLE) |-> $stable(mem_addr));

endmodule

// File: tb/tb_async_strobe_seq.sv
module tb_async_strobe_seq;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [30:0] cfg_wdata = '0;
  logic req = 0, req_write = 0;
  logic [1:0] req_cs = '0;
  logic [15:0] req_addr = '0, req_wdata = '0, mem_din = '0;
  logic mem_wait = 0;
  logic req_ready, done, mem_oe_n, mem_we_n, mem_doe;
  logic [15:0] rdata, mem_addr, mem_dout;
  logic [3:0] mem_cs_n, cs_nand, cs_ecc_start;

  int checks = 0, fails = 0;
  int n_total, n_cs, n_str, n_pre, n_doe, n_dbad, n_abad, n_both;
  logic [3:0] seen_cs;

  always #5 clk = ~clk;

  async_strobe_seq dut (.*);

  function automatic logic [30:0] tim(int rs, int rst, int rh, int ws, int wst,
                                      int wh, int ta, bit b16, bit ew, bit ss);
    logic [30:0] t;
    t = '0;
    t[3:0] = 4'(rs);  t[9:4] = 6'(rst); t[12:10] = 3'(rh);
    t[16:13] = 4'(ws); t[22:17] = 6'(wst); t[25:23] = 3'(wh);
    t[27:26] = 2'(ta); t[28] = b16; t[29] = ew; t[30] = ss;
    return t;
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cfg(bit sel, logic [30:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(bit wr, logic [1:0] cs, logic [15:0] a, logic [15:0] wd,
                        bit wmode, logic [15:0] dexp);
    @(negedge clk);
    req = 1; req_write = wr; req_cs = cs; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req = 0;
    n_total = 0; n_cs = 0; n_str = 0; n_pre = 0; n_doe = 0;
    n_dbad = 0; n_abad = 0; n_both = 0; seen_cs = 4'hF;
    while (n_total < 200) begin
      n_total++;
      if (!(&mem_cs_n)) begin n_cs++; seen_cs = mem_cs_n; end
      if (!mem_oe_n && !mem_we_n) n_both++;
      if (mem_addr != a) n_abad++;
      if (wr ? !mem_we_n : !mem_oe_n) begin
        n_str++;
        mem_din = 16'hA000 + 16'(n_str);
        mem_wait = wmode && (n_str < 10);
      end else if (n_str == 0) n_pre++;
      if (mem_doe) begin
        n_doe++;
        if (mem_dout != dexp) n_dbad++;
      end
      if (done) break;
      @(negedge clk);
    end
    mem_wait = 0;
  endtask

  task automatic t_reset;
    chk("R6 reset ready", req_ready, 1);
    chk("R11 reset cs", mem_cs_n, 4'hF);
    chk("R4 reset strobes", {mem_oe_n, mem_we_n}, 2'b11);
    chk("R12 reset nand", cs_nand, 0);
    chk("R12 reset ecc", cs_ecc_start, 0);
    chk("R6 reset done", done, 0);
  endtask

  task automatic t_read16;
    cfg(0, tim(2, 7, 0, 0, 6, 1, 2, 1, 0, 0));
    access(0, 2'd2, 16'h1234, 16'h0, 0, 16'h0);
    chk("R2 read setup", n_pre, 3);
    chk("R2 read strobe", n_str, 8);
    chk("R2 read hold", n_total - n_pre - n_str, 1);
    chk("R9 normal cs length", n_cs, 12);
    chk("R11 cs line", seen_cs, 4'b1011);
    chk("R2 addr stable", n_abad, 0);
    chk("R4 no data drive on read", n_doe, 0);
    @(negedge clk);
    chk("R5 capture last strobe", rdata, 16'hA008);
  endtask

  task automatic t_write8;
    cfg(0, tim(2, 7, 0, 0, 6, 1, 2, 0, 0, 0));
    access(1, 2'd1, 16'h0042, 16'hBEEF, 0, 16'h00EF);
    chk("R3 write setup", n_pre, 1);
    chk("R3 write strobe", n_str, 7);
    chk("R3 write total", n_total, 10);
    chk("R3 doe span", n_doe, 10);
    chk("R10 8-bit dout mask", n_dbad, 0);
    chk("R4 never both strobes", n_both, 0);
    chk("R11 cs line", seen_cs, 4'b1101);
  endtask

  task automatic t_read8;
    access(0, 2'd0, 16'h0007, 16'h0, 0, 16'h0);
    @(negedge clk);
    chk("R10 8-bit rdata", rdata, 16'h0008);
  endtask

  task automatic t_turnaround;
    int gap;
    bit rdy_early;
    access(1, 2'd3, 16'h0100, 16'h0055, 0, 16'h0055);
    req = 1;
    gap = 0;
    @(negedge clk);
    rdy_early = req_ready;
    while ((&mem_cs_n) && gap < 50) begin gap++; @(negedge clk); end
    req = 0;
    chk("R7 turnaround gap", gap, 3);
    chk("R6 not ready in gap", rdy_early, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_wait;
    access(0, 2'd0, 16'h0001, 16'h0, 1, 16'h0);
    chk("R8 wait ignored when off", n_str, 8);
    cfg(0, tim(2, 7, 0, 0, 6, 1, 2, 1, 1, 0));
    access(0, 2'd0, 16'h0002, 16'h0, 1, 16'h0);
    chk("R8 wait stretches strobe", n_str, 10);
    chk("R8 stretched total", n_total, 14);
    @(negedge clk);
    chk("R5 capture after stretch", rdata, 16'hA00A);
  endtask

  task automatic t_strobe_sel;
    cfg(0, tim(2, 7, 0, 0, 6, 1, 0, 1, 0, 1));
    access(0, 2'd1, 16'h0003, 16'h0, 0, 16'h0);
    chk("R9 select-strobe cs length", n_cs, 8);
    chk("R9 select-strobe total", n_total, 12);
    cfg(0, tim(0, 0, 0, 3, 1, 2, 0, 1, 0, 0));
    access(1, 2'd0, 16'h0004, 16'h1357, 0, 16'h1357);
    chk("R1 custom write total", n_total, 4 + 2 + 3);
    chk("R1 16-bit dout", n_dbad, 0);
  endtask

  task automatic t_flags;
    cfg(1, 31'h0000_0054);
    chk("R12 nand bits", cs_nand, 4'b0100);
    chk("R12 ecc bits", cs_ecc_start, 4'b0101);
    cfg(1, 31'h0000_0004);
    chk("R12 ecc cleared", cs_ecc_start, 4'b0000);
    chk("R12 nand kept", cs_nand, 4'b0100);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    #20 rst_n = 1;
    t_read16();
    t_write8();
    t_read8();
    t_turnaround();
    t_wait();
    t_strobe_sel();
    t_flags();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule